// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block turns a single-clock write request into a correctly timed write on an external asynchronous static RAM. A request carries an address, a data word and a style bit. The block drives the RAM address, the write data with its output enable, and the two active-low strobes, write enable and chip enable. Each minimum interval of the RAM write cycle is given as a nanosecond parameter. The block converts each one into whole clock cycles, rounding up against a clock-period parameter. Each strobe edge is then placed to meet its own setup or hold window; the block does not use one fixed pulse length.

Requests enter on a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. While the sequencer is busy, the requester must hold `req_valid` and the request fields until ready returns. Whatever is presented during that time has no effect on the RAM bus. `busy` is high from acceptance until the full write-cycle time has elapsed. `done` pulses for one cycle when the sequencer returns to idle. Read cycles are not generated, so the RAM output enable is held inactive.

Top module: `sram_wr_seq`

## Requirements
- R1: A request is accepted only when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is low exactly while `busy` is high, and a request presented while busy leaves `sram_addr` and the strobes unchanged.
- R2: On the edge after acceptance, `sram_addr` and `sram_dq` carry the accepted address and data, `sram_dq_oe` is 1, and both `sram_we_n` and `sram_ce_n` are 0, falling on the same edge (zero address setup). The word is written to the RAM when the terminating strobe rises.
- R3: Both strobes stay low together for S cycles. S is the largest of three values, each the ceiling of a nanosecond interval divided by the clock period: the terminating strobe's minimum low time, the data setup time before the rising edge, and the address setup time before the rising edge. S is at least 1. With the defaults, S = 7.
- R4: With `req_mode` = 0 (write-enable terminated), `sram_we_n` rises first and `sram_ce_n` follows HW cycles later. With `req_mode` = 1 (chip-enable terminated), `sram_ce_n` rises first and `sram_we_n` follows HC cycles later. HW and HC are the rounded-up address-hold times for each strobe, each at least 1; with the defaults, HW = 1 and HC = 2. `sram_addr` is stable throughout the hold.
- R5: `sram_dq_oe` is 1 only while a strobe is low. It falls only when both strobes are high, and it is 0 whenever the block is idle and during reset.
- R6: `busy` stays high for C = max(S + H, ceil(cycle time / period)) cycles, where H is HW or HC for the style in use. Two acceptances are therefore never closer than C cycles. With the defaults, C = 8 for mode 0 and 9 for mode 1.
- R7: `done` is high for exactly one cycle, in the first idle cycle after a write. It may coincide with the acceptance of the next request.
- R8: `sram_oe_n` is 1 at all times, including the cycles where both strobes fall together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_mode | input | 1 | 0: write enable ends the write; 1: chip enable ends it |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse on return to idle |
| sram_addr | output | ADDR_W | RAM address bus |
| sram_dq | output | DATA_W | RAM write data |
| sram_dq_oe | output | 1 | Drive enable for the RAM data bus |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low, held high |

## Verification
The end of one write and the acceptance of the next can fall in the same cycle. In that cycle `done` is high, `req_ready` is high, and a waiting request is taken. The bench provokes this by keeping `req_valid` high with a second request queued behind the first. Meanwhile it changes the queued fields during the busy window. It judges the result by three measurements: the gap between the two acceptances, which must equal the expected cycle count C; the presence of both `done` and ready at the boundary; and the address and data that appear on the bus on the very next cycle.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STROBE  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RECOVER = 2'd3
  } wr_phase_e;

  // ceiling of ns / period_ns
  function automatic int ns2cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int STROBE_WE = 7,
  parameter int STROBE_CE = 7,
  parameter int HOLD_WE   = 1,
  parameter int HOLD_CE   = 2,
  parameter int REC_WE    = 0,
  parameter int REC_CE    = 0,
  parameter int CNT_W     = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_mode,
  output wr_phase_e phase_q,
  output wr_phase_e phase_d,
  output logic      mode_q,
  output logic      mode_d,
  output logic      done_q
);

  localparam logic [CNT_W-1:0] LV_STROBE_WE = CNT_W'(STROBE_WE - 1);
  localparam logic [CNT_W-1:0] LV_STROBE_CE = CNT_W'(STROBE_CE - 1);
  localparam logic [CNT_W-1:0] LV_HOLD_WE   = CNT_W'(HOLD_WE - 1);
  localparam logic [CNT_W-1:0] LV_HOLD_CE   = CNT_W'(HOLD_CE - 1);
  localparam logic [CNT_W-1:0] LV_REC_WE    = CNT_W'((REC_WE == 0) ? 0 : REC_WE - 1);
  localparam logic [CNT_W-1:0] LV_REC_CE    = CNT_W'((REC_CE == 0) ? 0 : REC_CE - 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             rec_needed;

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign rec_needed = mode_q ? (REC_CE != 0) : (REC_WE != 0);

  always_comb begin
    phase_d  = phase_q;
    mode_d   = mode_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d  = PH_STROBE;
          mode_d   = start_mode;
          tmr_load = 1'b1;
          tmr_val  = start_mode ? LV_STROBE_CE : LV_STROBE_WE;
        end
      end
      PH_STROBE: begin
        if (tmr_expired) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = mode_q ? LV_HOLD_CE : LV_HOLD_WE;
        end
      end
      PH_HOLD: begin
        if (tmr_expired) begin
          if (rec_needed) begin
            phase_d  = PH_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = mode_q ? LV_REC_CE : LV_REC_WE;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_RECOVER: begin
        if (tmr_expired) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      done_q  <= (phase_q != PH_IDLE) && (phase_d == PH_IDLE);
    end
  end

endmodule

// File: rtl/sram_wr_bus.sv
module sram_wr_bus
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  wr_phase_e         phase_d,
  input  logic              mode_d,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq,
  output logic              sram_dq_oe,
  output logic              sram_we_n,
  output logic              sram_ce_n
);

  logic we_low_d;
  logic ce_low_d;
  logic drive_d;

  // the terminating strobe rises at the start of PH_HOLD, the other at its end
  always_comb begin
    we_low_d = (phase_d == PH_STROBE) || ((phase_d == PH_HOLD) && mode_d);
    ce_low_d = (phase_d == PH_STROBE) || ((phase_d == PH_HOLD) && !mode_d);
    drive_d  = (phase_d == PH_STROBE) || (phase_d == PH_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr  <= '0;
      sram_dq    <= '0;
      sram_dq_oe <= 1'b0;
      sram_we_n  <= 1'b1;
      sram_ce_n  <= 1'b1;
    end else begin
      if (capture) begin
        sram_addr <= in_addr;
        sram_dq   <= in_data;
      end
      sram_dq_oe <= drive_d;
      sram_we_n  <= !we_low_d;
      sram_ce_n  <= !ce_low_d;
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W          = 19,
  parameter int DATA_W          = 8,
  parameter int CLK_NS          = 10,
  parameter int WE_LOW_NS       = 55,
  parameter int CE_LOW_NS       = 55,
  parameter int DATA_SETUP_NS   = 30,
  parameter int ADDR_SETUP_NS   = 65,
  parameter int WE_ADDR_HOLD_NS = 5,
  parameter int CE_ADDR_HOLD_NS = 15,
  parameter int CYCLE_NS        = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_mode,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq,
  output logic              sram_dq_oe,
  output logic              sram_we_n,
  output logic              sram_ce_n,
  output logic              sram_oe_n
);

  localparam int SETUP_CYC = imax(ns2cyc(DATA_SETUP_NS, CLK_NS), ns2cyc(ADDR_SETUP_NS, CLK_NS));
  localparam int STROBE_WE = imax(1, imax(ns2cyc(WE_LOW_NS, CLK_NS), SETUP_CYC));
  localparam int STROBE_CE = imax(1, imax(ns2cyc(CE_LOW_NS, CLK_NS), SETUP_CYC));
  localparam int HOLD_WE   = imax(1, ns2cyc(WE_ADDR_HOLD_NS, CLK_NS));
  localparam int HOLD_CE   = imax(1, ns2cyc(CE_ADDR_HOLD_NS, CLK_NS));
  localparam int CYC_WE    = imax(STROBE_WE + HOLD_WE, ns2cyc(CYCLE_NS, CLK_NS));
  localparam int CYC_CE    = imax(STROBE_CE + HOLD_CE, ns2cyc(CYCLE_NS, CLK_NS));
  localparam int REC_WE    = CYC_WE - STROBE_WE - HOLD_WE;
  localparam int REC_CE    = CYC_CE - STROBE_CE - HOLD_CE;
  localparam int MAX_CNT   = imax(imax(STROBE_WE, STROBE_CE), imax(CYC_WE, CYC_CE));
  localparam int CNT_W     = imax(1, $clog2(MAX_CNT + 1));

  wr_phase_e phase_q;
  wr_phase_e phase_d;
  logic      mode_q;
  logic      mode_d;
  logic      accept;

  assign req_ready = (phase_q == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign sram_oe_n = 1'b1;

  sram_wr_ctrl #(
    .STROBE_WE (STROBE_WE),
    .STROBE_CE (STROBE_CE),
    .HOLD_WE   (HOLD_WE),
    .HOLD_CE   (HOLD_CE),
    .REC_WE    (REC_WE),
    .REC_CE    (REC_CE),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_valid),
    .start_mode (req_mode),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .done_q     (done)
  );

  sram_wr_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept),
    .in_addr    (req_addr),
    .in_data    (req_data),
    .phase_d    (phase_d),
    .mode_d     (mode_d),
    .sram_addr  (sram_addr),
    .sram_dq    (sram_dq),
    .sram_dq_oe (sram_dq_oe),
    .sram_we_n  (sram_we_n),
    .sram_ce_n  (sram_ce_n)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W    = 19,
  parameter int STROBE_WE = 7,
  parameter int STROBE_CE = 7,
  parameter int HOLD_WE   = 1,
  parameter int HOLD_CE   = 2,
  parameter int CYC_WE    = 8,
  parameter int CYC_CE    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_mode,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_dq_oe,
  input logic              sram_we_n,
  input logic              sram_ce_n
);

  int   low_cnt;
  int   hold_cnt;
  int   since_acc;
  int   need_gap;
  logic acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= 0;
      hold_cnt  <= 0;
      since_acc <= 1 << 20;
      need_gap  <= 0;
    end else begin
      low_cnt  <= (!sram_we_n && !sram_ce_n) ? low_cnt + 1 : 0;
      hold_cnt <= (sram_we_n != sram_ce_n) ? hold_cnt + 1 : 0;
      if (acc) begin
        since_acc <= 1;
        need_gap  <= req_mode ? CYC_CE : CYC_WE;
      end else if (since_acc < (1 << 20)) begin
        since_acc <= since_acc + 1;
      end
    end
  end

  // R1
  ignored_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(sram_addr));

  // R2
  accept_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!sram_we_n && !sram_ce_n && sram_dq_oe && sram_addr == $past(req_addr)));

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && !sram_ce_n) |-> (low_cnt == STROBE_WE));

  // R3
  ce_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_ce_n) && !sram_we_n) |-> (low_cnt == STROBE_CE));

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_ce_n) && sram_we_n) |-> (hold_cnt == HOLD_WE));

  // R4
  ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && sram_ce_n) |-> (hold_cnt == HOLD_CE));

  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n != sram_ce_n) |-> $stable(sram_addr));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_dq_oe) |-> (sram_we_n && sram_ce_n));

  // R5
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sram_dq_oe);

  // R6
  cycle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (since_acc >= need_gap));

  // R7
  done_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
  .ADDR_W    (ADDR_W),
  .STROBE_WE (STROBE_WE),
  .STROBE_CE (STROBE_CE),
  .HOLD_WE   (HOLD_WE),
  .HOLD_CE   (HOLD_CE),
  .CYC_WE    (CYC_WE),
  .CYC_CE    (CYC_CE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_mode   (req_mode),
  .busy       (busy),
  .done       (done),
  .sram_addr  (sram_addr),
  .sram_dq_oe (sram_dq_oe),
  .sram_we_n  (sram_we_n),
  .sram_ce_n  (sram_ce_n)
);

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;

  localparam int AW  = 19;
  localparam int DW  = 8;
  localparam int PER = 10;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int exp_strobe(input bit m);
    return mx(1, mx(cdiv(55), mx(cdiv(30), cdiv(65))));
  endfunction

  function automatic int exp_hold(input bit m);
    return mx(1, cdiv(m ? 15 : 5));
  endfunction

  function automatic int exp_cycle(input bit m);
    return mx(exp_strobe(m) + exp_hold(m), cdiv(70));
  endfunction

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_mode;
  logic          busy;
  logic          done;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq;
  logic          sram_dq_oe;
  logic          sram_we_n;
  logic          sram_ce_n;
  logic          sram_oe_n;

  logic [DW-1:0] mem [bit [AW-1:0]];
  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sram_wr_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_mode   (req_mode),
    .busy       (busy),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_dq    (sram_dq),
    .sram_dq_oe (sram_dq_oe),
    .sram_we_n  (sram_we_n),
    .sram_ce_n  (sram_ce_n),
    .sram_oe_n  (sram_oe_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit m);
    int  lo;
    int  ho;
    int  tot;
    bit  addr_bad;
    bit  oen_bad;
    lo = 0; ho = 0; tot = 0; addr_bad = 0; oen_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_mode = m;
    chk(req_ready && !busy, "R1 ready while idle", {req_ready, busy}, 2'b10);
    @(negedge clk);
    req_valid = 1'b0; req_addr = AW'($urandom); req_data = DW'($urandom); req_mode = ~m;
    chk(busy && !req_ready, "R1 ready low while busy", {busy, req_ready}, 2'b10);
    chk(!sram_we_n && !sram_ce_n && sram_dq_oe && sram_addr == a && sram_dq == d,
        "R2 bus after accept", {sram_we_n, sram_ce_n, sram_dq_oe, sram_addr, sram_dq},
        {2'b00, 1'b1, a, d});
    while (!sram_we_n && !sram_ce_n && lo < 1000) begin
      if (sram_addr != a) addr_bad = 1;
      if (!sram_oe_n) oen_bad = 1;
      lo++; tot++;
      @(negedge clk);
    end
    chk(lo == exp_strobe(m), "R3 strobe low cycles", lo, exp_strobe(m));
    chk(m ? (sram_ce_n && !sram_we_n) : (sram_we_n && !sram_ce_n),
        "R4 terminating strobe", {sram_we_n, sram_ce_n}, m ? 2'b01 : 2'b10);
    mem[sram_addr] = sram_dq;
    while ((sram_we_n != sram_ce_n) && ho < 1000) begin
      if (sram_addr != a) addr_bad = 1;
      if (!sram_oe_n) oen_bad = 1;
      if (!sram_dq_oe) oen_bad = 1;
      ho++; tot++;
      @(negedge clk);
    end
    chk(ho == exp_hold(m), "R4 hold cycles", ho, exp_hold(m));
    chk(!addr_bad, "R4 address stable", addr_bad, 0);
    chk(!oen_bad && sram_oe_n, "R8 output enable high", oen_bad, 0);
    chk(!sram_dq_oe, "R5 data released", sram_dq_oe, 0);
    while (busy && tot < 1000) begin
      tot++;
      @(negedge clk);
    end
    chk(tot == exp_cycle(m), "R6 busy cycles", tot, exp_cycle(m));
    chk(done, "R7 done on idle", done, 1);
    chk(mem[a] == d, "R2 word written", mem[a], d);
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
  endtask

  task automatic b2b(input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                     input logic [AW-1:0] a2, input logic [DW-1:0] d2, input bit m);
    int gap;
    bit bad;
    gap = 0; bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a1; req_data = d1; req_mode = m;
    @(negedge clk);
    req_addr = a2; req_data = d2;
    while (busy && gap < 1000) begin
      if (sram_addr != a1) bad = 1;
      gap++;
      @(negedge clk);
    end
    chk(!bad, "R1 queued request ignored while busy", bad, 0);
    chk(gap == exp_cycle(m), "R6 acceptance spacing", gap, exp_cycle(m));
    chk(done && req_ready, "R7 done with next accept", {done, req_ready}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && sram_addr == a2 && sram_dq == d2 && !sram_we_n && !sram_ce_n,
        "R2 back-to-back bus", {sram_addr, sram_dq}, {a2, d2});
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [AW-1:0] held;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(sram_we_n && sram_ce_n && sram_oe_n && !sram_dq_oe && !busy && req_ready && !done,
        "R5 reset state",
        {sram_we_n, sram_ce_n, sram_oe_n, sram_dq_oe, busy, req_ready, done}, 7'b1110010);
    rst_n = 1'b1;
    @(negedge clk);

    do_write('0, 8'hA5, 1'b0);
    do_write('1, 8'h5A, 1'b1);

    held = sram_addr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      req_addr = AW'($urandom);
    end
    @(negedge clk);
    chk(sram_addr == held && sram_we_n && sram_ce_n && !busy,
        "R1 no request without valid", sram_addr, held);

    b2b(19'h12345, 8'h11, 19'h54321, 8'h22, 1'b0);
    b2b(19'h0F0F0, 8'h33, 19'h70F0F, 8'h44, 1'b1);

    for (int i = 0; i < 40; i++) begin
      do_write(AW'($urandom), DW'($urandom), 1'($urandom));
    end

    finish_run();
  end

endmodule